// File: doc/BRIEF.md
# Averaged Full-Bridge Converter State Solver

This block advances a discretized, averaged model of a single-phase full-bridge converter by one integration step each time it is strobed. The model has two state variables: the inductor current on the AC side and the DC-bus voltage. The bridge itself is not modelled switch by switch. It is replaced by a controlled voltage source of value u·vdc on the AC side and a controlled current source of value u·ia on the DC side. Both states are advanced with forward-Euler equations whose coefficients are computed from the step time, the inductor, its series resistance and the bus capacitor.

A real-time emulator places the block inside a fixed-rate loop. The intended step period is 6 µs. It feeds the block the present grid voltage, the photovoltaic panel current and a load coefficient that software may change while the loop runs. A loop-select input picks one of two modulating signals. In open-loop tests the emulator's own setting is used. In closed-loop tests the signal comes from the controller under test. Every quantity is a signed fixed-point word. Both states are clamped to their physical ranges, so the words never wrap.

Top module: `hb_avg_emu`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first update, `ia_o` and `vdc_o` read 0 and `done_o` is low.
- R2: On each accepted step, the new current is computed from the previous states only. First `uv = (u·vdc) >>> 14`. Then `ia_new = (KA·ia + KL·(uv − vg)) >>> 30`. Here `ia`, `vdc`, `vg` and `ipv` are Q16.16 words, `u` is Q2.14, and KA = round((1 − r·T/L)·2^30) and KL = round((T/L)·2^30). Both shifts are arithmetic, which truncates toward minus infinity.
- R3: On the same step, `ui = (u·ia) >>> 14` and `vdc_new = (KR·vdc + KC·(ipv − ui)) >>> 30`. KC = round((T/C)·2^30), and KR is the value on `k_load_i`.
- R4: `k_load_i` is a Q2.30 word sampled at every accepted step, so a changed load coefficient takes effect on the very next step.
- R5: With `closed_i` = 1 the modulating signal is `u_ctl_i`, and with `closed_i` = 0 it is `u_open_i`. The input that is not selected has no effect on either state.
- R6: Before it is used, the selected modulating signal is limited to the range −16384..16384 (±1.0 in Q2.14).
- R7: The current state is limited to ±256 A, that is ±16777216 in Q16.16.
- R8: The DC voltage state is limited to 0..512 V, that is 0..33554432 in Q16.16.
- R9: A `step_i` high at a rising edge is accepted. The new states and a one-cycle `done_o` pulse both appear after the second rising edge from that point. At all other times the states hold their values.
- R10: A `step_i` high at the rising edge right after an accepted step is ignored. It produces no second update and no second `done_o` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Integration step strobe |
| closed_i | input | 1 | 1 selects the external modulating signal, 0 selects the open-loop setting |
| u_ctl_i | input | 16 | External modulating signal, Q2.14 |
| u_open_i | input | 16 | Open-loop modulating signal, Q2.14 |
| vg_i | input | 32 | Grid voltage sample, Q16.16 volts |
| ipv_i | input | 32 | Panel current, Q16.16 amperes |
| k_load_i | input | 32 | Load decay coefficient 1 − T/(R·C), Q2.30 |
| ia_o | output | 32 | Inductor current state, Q16.16 amperes |
| vdc_o | output | 32 | DC-bus voltage state, Q16.16 volts |
| done_o | output | 1 | One-cycle pulse when both new states are registered |

## Verification
The range assertions take for granted that grid and panel words stay within about ±30000 units. The range checks themselves do not depend on this, but the update arithmetic only stays free of overflow inside its wide accumulator when this holds. The stimulus keeps every such input at 25000 units or less. The timing assertions assume that `step_i` is low while reset is applied. The bench raises and lowers the strobe only on falling edges, holds all data inputs steady from the strobe until the result is checked, and drives modulating values beyond ±1.0 only to exercise the limiter.

// File: rtl/hb_avg_pkg.sv
package hb_avg_pkg;
   localparam int HB_SW = 32;  // state word width
   localparam int HB_FB = 16;  // state fraction bits
   localparam int HB_UW = 16;  // modulating word width
   localparam int HB_UF = 14;  // modulating fraction bits
   localparam int HB_CW = 32;  // coefficient width
   localparam int HB_CF = 30;  // coefficient fraction bits

   typedef enum logic {
      LOOP_OPEN   = 1'b0,
      LOOP_CLOSED = 1'b1
   } loop_e;
endpackage

// File: rtl/hb_mul_shift.sv
module hb_mul_shift #(
   parameter int AW = 16,
   parameter int BW = 32,
   parameter int SH = 14,
   parameter int OW = 32
) (
   input  logic signed [AW-1:0] a_i,
   input  logic signed [BW-1:0] b_i,
   output logic signed [OW-1:0] p_o
);
   localparam int PW = AW + BW;

   if (OW > PW) begin : g_bad_width
      $error("hb_mul_shift: output wider than product");
   end
   if (SH >= PW) begin : g_bad_shift
      $error("hb_mul_shift: shift exceeds product width");
   end

   logic signed [PW-1:0] full;

   always_comb begin
      full = PW'(a_i) * PW'(b_i);
      p_o  = OW'(full >>> SH);
   end
endmodule

// File: rtl/hb_state_upd.sv
module hb_state_upd #(
   parameter int SW = 32,
   parameter int CW = 32,
   parameter int CF = 30,
   parameter logic signed [SW-1:0] LO = '0,
   parameter logic signed [SW-1:0] HI = '0
) (
   input  logic signed [CW-1:0] k0_i,   // state decay coefficient
   input  logic signed [CW-1:0] k1_i,   // drive gain coefficient
   input  logic signed [SW-1:0] x_i,    // previous state
   input  logic signed [SW-1:0] a_i,    // positive drive term
   input  logic signed [SW-1:0] b_i,    // negative drive term
   output logic signed [SW-1:0] nxt_o
);
   localparam int PW = CW + SW + 2;

   if (CF >= CW) begin : g_bad_frac
      $error("hb_state_upd: coefficient fraction too wide");
   end
   if (LO > HI) begin : g_bad_bounds
      $error("hb_state_upd: lower bound above upper bound");
   end

   logic signed [SW:0]   diff;
   logic signed [PW-1:0] acc;
   logic signed [PW-1:0] shd;

   always_comb begin
      diff = (SW+1)'(a_i) - (SW+1)'(b_i);
      acc  = PW'(k0_i) * PW'(x_i) + PW'(k1_i) * PW'(diff);
      shd  = acc >>> CF;
      if (shd > PW'(HI))
         nxt_o = HI;
      else if (shd < PW'(LO))
         nxt_o = LO;
      else
         nxt_o = shd[SW-1:0];
   end
endmodule

// File: rtl/hb_step_ctl.sv
module hb_step_ctl #(
   parameter int PIPE = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic step_i,
   output logic cap_o,   // capture operands
   output logic upd_o,   // load state registers
   output logic done_o
);
   logic done_q;

   if (PIPE == 0) begin : g_direct
      assign cap_o = step_i;
      assign upd_o = step_i;
   end else begin : g_staged
      logic busy_q;
      assign cap_o = step_i & ~busy_q;
      assign upd_o = busy_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) busy_q <= 1'b0;
         else        busy_q <= cap_o;
      end

      // done two edges after an accepted strobe
      assert_done_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
         done_o |-> $past(cap_o, 2));
      // a strobe during the busy cycle never yields a second pulse
      assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
         done_o |=> !done_o);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) done_q <= 1'b0;
      else        done_q <= upd_o;
   end
   assign done_o = done_q;
endmodule

// File: rtl/hb_avg_emu.sv
module hb_avg_emu
   import hb_avg_pkg::*;
#(
   parameter int  SW        = HB_SW,
   parameter int  FB        = HB_FB,
   parameter int  UW        = HB_UW,
   parameter int  UF        = HB_UF,
   parameter int  CW        = HB_CW,
   parameter int  CF        = HB_CF,
   parameter int  PIPE      = 1,
   parameter int  IA_MAX_A  = 256,
   parameter int  VDC_MAX_V = 512,
   parameter real T_STEP    = 6.0e-6,
   parameter real R_IND     = 0.4,
   parameter real L_IND     = 4.1e-3,
   parameter real C_BUS     = 4576.0e-6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step_i,
   input  logic                 closed_i,
   input  logic signed [UW-1:0] u_ctl_i,
   input  logic signed [UW-1:0] u_open_i,
   input  logic signed [SW-1:0] vg_i,
   input  logic signed [SW-1:0] ipv_i,
   input  logic signed [CW-1:0] k_load_i,
   output logic signed [SW-1:0] ia_o,
   output logic signed [SW-1:0] vdc_o,
   output logic                 done_o
);
   localparam logic signed [SW-1:0] IA_HI  = SW'(IA_MAX_A * (2 ** FB));
   localparam logic signed [SW-1:0] IA_LO  = -IA_HI;
   localparam logic signed [SW-1:0] VDC_HI = SW'(VDC_MAX_V * (2 ** FB));
   localparam logic signed [SW-1:0] VDC_LO = '0;
   localparam logic signed [UW-1:0] ONE_U  = UW'(2 ** UF);
   localparam logic signed [UW-1:0] MONE_U = -ONE_U;
   localparam logic signed [CW-1:0] K_A =
      CW'($rtoi((1.0 - R_IND * T_STEP / L_IND) * (2.0 ** CF) + 0.5));
   localparam logic signed [CW-1:0] K_L =
      CW'($rtoi((T_STEP / L_IND) * (2.0 ** CF) + 0.5));
   localparam logic signed [CW-1:0] K_C =
      CW'($rtoi((T_STEP / C_BUS) * (2.0 ** CF) + 0.5));

   if (PIPE < 0 || PIPE > 1) begin : g_bad_pipe
      $error("hb_avg_emu: PIPE must be 0 or 1");
   end
   if (UF > UW - 2) begin : g_bad_u
      $error("hb_avg_emu: modulating word needs two integer bits");
   end
   if (CF > CW - 2) begin : g_bad_coef
      $error("hb_avg_emu: coefficient word needs two integer bits");
   end
   if (FB + $clog2(VDC_MAX_V) + 1 >= SW || FB + $clog2(IA_MAX_A) + 1 >= SW) begin : g_bad_range
      $error("hb_avg_emu: state word too narrow for its range");
   end

   // modulating signal select and limit
   loop_e               loop_sel;
   logic signed [UW-1:0] u_raw;
   logic signed [UW-1:0] u_eff;

   always_comb begin
      loop_sel = loop_e'(closed_i);
      u_raw    = (loop_sel == LOOP_CLOSED) ? u_ctl_i : u_open_i;
      if (u_raw > ONE_U)       u_eff = ONE_U;
      else if (u_raw < MONE_U) u_eff = MONE_U;
      else                     u_eff = u_raw;
   end

   // sequencing
   logic cap, upd;

   hb_step_ctl #(.PIPE(PIPE)) u_ctl (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step_i),
      .cap_o  (cap),
      .upd_o  (upd),
      .done_o (done_o)
   );

   // state registers
   logic signed [SW-1:0] ia_q, vdc_q;
   logic signed [SW-1:0] ia_nxt, vdc_nxt;

   // bridge source terms from the previous states
   logic signed [SW-1:0] uv_c, ui_c;

   hb_mul_shift #(.AW(UW), .BW(SW), .SH(UF), .OW(SW)) u_src_v (
      .a_i (u_eff),
      .b_i (vdc_q),
      .p_o (uv_c)
   );

   hb_mul_shift #(.AW(UW), .BW(SW), .SH(UF), .OW(SW)) u_src_i (
      .a_i (u_eff),
      .b_i (ia_q),
      .p_o (ui_c)
   );

   // operand stage: registered or direct
   logic signed [SW-1:0] uv_s, ui_s, vg_s, ipv_s;
   logic signed [CW-1:0] kl_s;

   if (PIPE == 1) begin : g_opnd_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            uv_s  <= '0;
            ui_s  <= '0;
            vg_s  <= '0;
            ipv_s <= '0;
            kl_s  <= '0;
         end else if (cap) begin
            uv_s  <= uv_c;
            ui_s  <= ui_c;
            vg_s  <= vg_i;
            ipv_s <= ipv_i;
            kl_s  <= k_load_i;
         end
      end
   end else begin : g_opnd_direct
      assign uv_s  = uv_c;
      assign ui_s  = ui_c;
      assign vg_s  = vg_i;
      assign ipv_s = ipv_i;
      assign kl_s  = k_load_i;
   end

   // inductor current: KA*ia + KL*(u*vdc - vg)
   hb_state_upd #(.SW(SW), .CW(CW), .CF(CF), .LO(IA_LO), .HI(IA_HI)) u_upd_ia (
      .k0_i  (K_A),
      .k1_i  (K_L),
      .x_i   (ia_q),
      .a_i   (uv_s),
      .b_i   (vg_s),
      .nxt_o (ia_nxt)
   );

   // bus voltage: KR*vdc + KC*(ipv - u*ia)
   hb_state_upd #(.SW(SW), .CW(CW), .CF(CF), .LO(VDC_LO), .HI(VDC_HI)) u_upd_vdc (
      .k0_i  (kl_s),
      .k1_i  (K_C),
      .x_i   (vdc_q),
      .a_i   (ipv_s),
      .b_i   (ui_s),
      .nxt_o (vdc_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ia_q  <= '0;
         vdc_q <= '0;
      end else if (upd) begin
         ia_q  <= ia_nxt;
         vdc_q <= vdc_nxt;
      end
   end

   assign ia_o  = ia_q;
   assign vdc_o = vdc_q;

   assert_ia_bounds_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ia_o <= IA_HI) && (ia_o >= IA_LO));
   assert_vdc_bounds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (vdc_o <= VDC_HI) && (vdc_o >= VDC_LO));
   assert_hold_between_steps_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((ia_o != $past(ia_o)) || (vdc_o != $past(vdc_o))) |-> done_o);
   assert_sel_closed_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (closed_i && (u_ctl_i <= ONE_U) && (u_ctl_i >= MONE_U)) |-> (u_eff == u_ctl_i));
endmodule

// File: tb/test_hb_avg_emu.sv
module test_hb_avg_emu;
   localparam real T_STEP = 6.0e-6;
   localparam real R_IND  = 0.4;
   localparam real L_IND  = 4.1e-3;
   localparam real C_BUS  = 4576.0e-6;
   localparam longint KA = longint'($rtoi((1.0 - R_IND * T_STEP / L_IND) * 1073741824.0 + 0.5));
   localparam longint KL = longint'($rtoi((T_STEP / L_IND) * 1073741824.0 + 0.5));
   localparam longint KC = longint'($rtoi((T_STEP / C_BUS) * 1073741824.0 + 0.5));
   localparam longint Q  = 65536;
   localparam longint IA_LIM  = 256 * Q;
   localparam longint VDC_LIM = 512 * Q;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic step_i = 1'b0;
   logic closed_i = 1'b0;
   logic signed [15:0] u_ctl_i = '0, u_open_i = '0;
   logic signed [31:0] vg_i = '0, ipv_i = '0, k_load_i = '0;
   logic signed [31:0] ia_o, vdc_o;
   logic done_o;

   int checks = 0;
   int failures = 0;
   longint m_ia = 0, m_vdc = 0;

   always #10 clk = ~clk;

   hb_avg_emu i_hb_avg_emu (
      .clk(clk), .rst_n(rst_n), .step_i(step_i), .closed_i(closed_i),
      .u_ctl_i(u_ctl_i), .u_open_i(u_open_i), .vg_i(vg_i), .ipv_i(ipv_i),
      .k_load_i(k_load_i), .ia_o(ia_o), .vdc_o(vdc_o), .done_o(done_o)
   );

   function automatic longint kload(input real r_ohm);
      return longint'($rtoi((1.0 - T_STEP / (r_ohm * C_BUS)) * 1073741824.0 + 0.5));
   endfunction

   task automatic chk(input string req, input longint act, input longint exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model(input longint u_in, input longint vg, input longint ipv, input longint kl);
      longint u, uv, ui, ni, nv;
      u = u_in;
      if (u > 16384) u = 16384;       // R6
      if (u < -16384) u = -16384;
      uv = (u * m_vdc) >>> 14;
      ui = (u * m_ia) >>> 14;
      ni = (KA * m_ia + KL * (uv - vg)) >>> 30;
      nv = (kl * m_vdc + KC * (ipv - ui)) >>> 30;
      if (ni > IA_LIM) ni = IA_LIM;   // R7
      if (ni < -IA_LIM) ni = -IA_LIM;
      if (nv > VDC_LIM) nv = VDC_LIM; // R8
      if (nv < 0) nv = 0;
      m_ia = ni;
      m_vdc = nv;
   endtask

   // one accepted step; sel is the used signal, oth goes to the unused input (R5)
   task automatic do_step(input longint sel, input longint oth, input bit cl,
                          input longint vg, input longint ipv, input longint kl,
                          input string req);
      @(negedge clk);
      closed_i = cl;
      u_ctl_i  = cl ? 16'(sel) : 16'(oth);
      u_open_i = cl ? 16'(oth) : 16'(sel);
      vg_i = 32'(vg); ipv_i = 32'(ipv); k_load_i = 32'(kl);
      step_i = 1'b1;
      @(negedge clk);
      step_i = 1'b0;
      chk({"R9 done not early ", req}, longint'(done_o), 0);
      model(sel, vg, ipv, kl);
      @(negedge clk);
      chk({"R9 done pulse ", req}, longint'(done_o), 1);
      chk({"R2 ia ", req}, longint'(ia_o), m_ia);
      chk({"R3 vdc ", req}, longint'(vdc_o), m_vdc);
      @(negedge clk);
      chk({"R9 done low ", req}, longint'(done_o), 0);
   endtask

   initial begin
      #(20 * 150000);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      longint ulist[8] = '{-31130, -16384, -8192, 0, 4096, 12288, 16384, 28672};
      longint vlist[5] = '{-180, -90, 0, 90, 180};
      longint plist[4] = '{0, 3 * 65536, 491520, -131072};
      longint kl50, kl20;
      longint prev_ia, prev_vdc;
      kl50 = kload(50.0);
      kl20 = kload(20.0);

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 ia reset", longint'(ia_o), 0);
      chk("R1 vdc reset", longint'(vdc_o), 0);
      chk("R1 done reset", longint'(done_o), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R1 ia after release", longint'(ia_o), 0);
      chk("R1 done after release", longint'(done_o), 0);

      // charge the bus first
      for (int i = 0; i < 7; i++)
         do_step(0, 5000, 1'b0, 0, 25000 * Q, kl50, "charge");

      // R2 R3 R5 R6: sweep of modulation, grid, panel, loop select, load
      for (int iu = 0; iu < 8; iu++)
         for (int iv = 0; iv < 5; iv++)
            for (int ip = 0; ip < 4; ip++)
               do_step(ulist[iu], -ulist[iu] + 777, 1'((iu + iv + ip) % 2),
                       vlist[iv] * Q, plist[ip], (ip % 2) ? kl20 : kl50, "R5 R6 sweep");

      // R4: load coefficient changes take effect at once
      do_step(8192, 0, 1'b1, 90 * Q, 2 * Q, kload(20.0), "R4 load 20");
      do_step(8192, 0, 1'b1, 90 * Q, 2 * Q, kload(200.0), "R4 load 200");
      do_step(8192, 0, 1'b1, 90 * Q, 2 * Q, kload(5.0), "R4 load 5");

      // R9: states hold while idle
      prev_ia = longint'(ia_o);
      prev_vdc = longint'(vdc_o);
      vg_i = 32'(100 * Q); ipv_i = 32'(50 * Q);
      repeat (5) @(negedge clk);
      chk("R9 ia hold idle", longint'(ia_o), prev_ia);
      chk("R9 vdc hold idle", longint'(vdc_o), prev_vdc);
      chk("R9 no done idle", longint'(done_o), 0);

      // R10: strobe held two cycles gives one update
      @(negedge clk);
      closed_i = 1'b0; u_open_i = 16'(4096); u_ctl_i = 16'(-9000);
      vg_i = 32'(-50 * Q); ipv_i = 32'(4 * Q); k_load_i = 32'(kl50);
      step_i = 1'b1;
      @(negedge clk);
      model(4096, -50 * Q, 4 * Q, kl50);
      @(negedge clk);
      step_i = 1'b0;
      chk("R10 done first", longint'(done_o), 1);
      chk("R10 ia single", longint'(ia_o), m_ia);
      chk("R10 vdc single", longint'(vdc_o), m_vdc);
      @(negedge clk);
      chk("R10 no second done", longint'(done_o), 0);
      @(negedge clk);
      chk("R10 no second done later", longint'(done_o), 0);
      chk("R10 ia unchanged", longint'(ia_o), m_ia);
      chk("R10 vdc unchanged", longint'(vdc_o), m_vdc);

      // R8: upper voltage limit
      for (int i = 0; i < 20; i++)
         do_step(0, 16384, 1'b1, 0, 25000 * Q, kl50, "R8 charge");
      chk("R8 vdc at 512 V", longint'(vdc_o), VDC_LIM);

      // R7: positive current limit
      for (int i = 0; i < 12; i++)
         do_step(0, 16384, 1'b0, -20000 * Q, 0, kl50, "R7 pos");
      chk("R7 ia at +256 A", longint'(ia_o), IA_LIM);

      // R7: negative current limit
      for (int i = 0; i < 25; i++)
         do_step(0, -16384, 1'b1, 20000 * Q, 0, kl50, "R7 neg");
      chk("R7 ia at -256 A", longint'(ia_o), -IA_LIM);

      // R8: lower voltage limit
      for (int i = 0; i < 25; i++)
         do_step(0, 16384, 1'b0, 20000 * Q, -25000 * Q, kl50, "R8 drain");
      chk("R8 vdc at 0 V", longint'(vdc_o), 0);

      // R6 at the limits with a charged bus
      for (int i = 0; i < 8; i++)
         do_step(0, 0, 1'b0, 0, 20000 * Q, kl50, "recharge");
      do_step(32000, -32000, 1'b1, 180 * Q, 0, kl50, "R6 over +1");
      do_step(-32000, 32000, 1'b0, -180 * Q, 0, kl50, "R6 under -1");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule